// File: doc/BRIEF.md
# Repeating Digit Sequence Generator

This block is a synchronous Moore state machine that drives a 3-bit code. After a reset it shows the code 0 for exactly one cycle. It then cycles through the group 1, 7, 1 with no end, so the output reads 0, 1, 7, 1, 1, 7, 1, 1, 7, ... The same code also feeds a seven-segment pattern encoder, so the digit can go straight to a display.

The state register is two flip-flops. There are four named states:
- `ST_ZERO` (00) is the post-reset state and shows 0.
- `ST_ONE_A` (01) shows 1 and always leads to 7.
- `ST_SEVEN` (11) shows 7.
- `ST_ONE_B` (10) shows 1 and always leads to the other 1.

The named transitions are:
- `ST_ZERO` → `ST_ONE_A`, on the first clock after reset is released.
- `ST_ONE_A` → `ST_SEVEN`.
- `ST_SEVEN` → `ST_ONE_B`.
- `ST_ONE_B` → `ST_ONE_A`.
- Any state → `ST_ZERO`, when reset is high at a clock edge.

The encoding is chosen so that no decode table is needed. The low code bit is the OR of the two state bits, and the two upper code bits are both the AND of the two state bits.

Top module: `seq_digit_gen`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, the next state is `ST_ZERO` from any present state, and `code_o` reads 0 in the following cycle.
- R2: While `rst` stays high, `code_o` stays 0.
- R3: After `rst` falls, `code_o` shows 0 once and then 1, 7, 1, 1, 7, 1, ..., advancing once per clock. Code 0 never appears again until the next reset.
- R4: A 7 is always followed by a 1. A 1 that follows a 7 is followed by another 1. A 1 that follows a 1 or a 0 is followed by a 7.
- R5: `code_o[0]` is the OR of the two state bits, and `code_o[2:1]` are both the AND of the two state bits. So the states read 00→0, 01→1, 11→7 and 10→1, and the only codes ever output are 0, 1 and 7.
- R6: The outputs depend only on the present state. A change of `rst` between clock edges does not change `code_o` or `seg_o`.
- R7: `seg_o` is active high, with bit 0 = segment a through bit 6 = segment g. Code 0 gives 7'b0111111, code 1 gives 7'b0000110, and code 7 gives 7'b0000111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| code_o | output | 3 | Present digit code (0, 1 or 7) |
| seg_o | output | 7 | Seven-segment pattern, bit 0 = a ... bit 6 = g, active high |

## Verification
The bench releases reset and then applies it again after every step count from zero to several periods. This reaches each of the four states, including both 1 states. A design whose reset missed one state, or that merged the two 1 states, would fail to return to 0 or would emit 1, 7, 1, 7.

It checks that a 0 never reappears without reset and that the pattern has period three. A wrong encoding would show up as a 3 or 6 code, or as a 7 where a 1 is expected.

It also toggles reset between edges and samples the outputs. This exposes a Mealy-style leak of reset into the code. Every cycle, the segment pattern is compared with the value expected for the digit.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;
    localparam int STATE_W = 2;
    localparam int CODE_W  = 3;
    localparam int SEG_W   = 7;

    typedef enum logic [STATE_W-1:0] {
        ST_ZERO  = 2'b00,
        ST_ONE_A = 2'b01,
        ST_SEVEN = 2'b11,
        ST_ONE_B = 2'b10
    } state_t;

    localparam logic [SEG_W-1:0] SEG_DIGIT0 = 7'b0111111;
    localparam logic [SEG_W-1:0] SEG_DIGIT1 = 7'b0000110;
    localparam logic [SEG_W-1:0] SEG_DIGIT7 = 7'b0000111;
    localparam logic [SEG_W-1:0] SEG_BLANK  = 7'b0000000;
endpackage

// File: rtl/seqgen_state_reg.sv
module seqgen_state_reg
    import seqgen_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output state_t state_o
);
    state_t state_q;
    state_t state_d;

    // next-state logic; reset acts as a machine input
    always_comb begin
        state_d = ST_ZERO;
        if (!rst) begin
            unique case (state_q)
                ST_ZERO:  state_d = ST_ONE_A;
                ST_ONE_A: state_d = ST_SEVEN;
                ST_SEVEN: state_d = ST_ONE_B;
                ST_ONE_B: state_d = ST_ONE_A;
                default:  state_d = ST_ZERO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign state_o = state_q;

    // R1: reset wins from any state
    assert_reset_to_zero_R1: assert property (@(posedge clk)
        rst |=> (state_q == ST_ZERO));

    // R3: the zero state is entered only through reset
    assert_zero_only_on_reset_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (state_q != ST_ZERO));
endmodule

// File: rtl/seqgen_code_out.sv
module seqgen_code_out
    import seqgen_pkg::*;
(
    input  state_t            state_i,
    output logic [CODE_W-1:0] code_o
);
    logic any_bit;
    logic both_bits;

    always_comb begin
        any_bit   = state_i[1] | state_i[0];
        both_bits = state_i[1] & state_i[0];
        code_o    = {both_bits, both_bits, any_bit};
    end

    // R5: upper bits always equal, and set only with the low bit set
    always_comb begin
        assert_code_shape_R5: assert (code_o[2] == code_o[1] && (!code_o[1] || code_o[0]));
    end
endmodule

// File: rtl/seqgen_seg_enc.sv
module seqgen_seg_enc
    import seqgen_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [SEG_W-1:0]  seg_o
);
    always_comb begin
        unique case (code_i)
            3'd0:    seg_o = SEG_DIGIT0;
            3'd1:    seg_o = SEG_DIGIT1;
            3'd7:    seg_o = SEG_DIGIT7;
            default: seg_o = SEG_BLANK;
        endcase
    end
endmodule

// File: rtl/seq_digit_gen.sv
module seq_digit_gen
    import seqgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [CODE_W-1:0] code_o,
    output logic [SEG_W-1:0]  seg_o
);
    state_t state;

    seqgen_state_reg u_state (
        .clk     (clk),
        .rst     (rst),
        .state_o (state)
    );

    seqgen_code_out u_code (
        .state_i (state),
        .code_o  (code_o)
    );

    seqgen_seg_enc u_seg (
        .code_i (code_o),
        .seg_o  (seg_o)
    );

    // R4: a seven is followed by a one
    assert_seven_then_one_R4: assert property (@(posedge clk) disable iff (rst)
        (code_o == 3'd7) |=> (code_o == 3'd1));

    // R4: zero is followed by a one
    assert_zero_then_one_R4: assert property (@(posedge clk) disable iff (rst)
        (code_o == 3'd0) |=> (code_o == 3'd1));

    // R4: two ones in a row lead to seven
    assert_one_one_then_seven_R4: assert property (@(posedge clk) disable iff (rst)
        (code_o == 3'd1 && $past(code_o) == 3'd1) |=> (code_o == 3'd7));

    // R7: segment count matches the digit
    assert_seg_count_R7: assert property (@(posedge clk) disable iff (rst)
        (code_o == 3'd1) |-> ($countones(seg_o) == 2));
endmodule

// File: tb/tb_seq_digit_gen.sv
module tb_seq_digit_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] code_o;
    logic [6:0] seg_o;
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    seq_digit_gen dut (
        .clk    (clk),
        .rst    (rst),
        .code_o (code_o),
        .seg_o  (seg_o)
    );

    function automatic int exp_code(int i);
        if (i == 0) return 0;
        return ((i - 1) % 3 == 1) ? 7 : 1;
    endfunction

    function automatic int exp_seg(int c);
        case (c)
            0:       return 7'b0111111;
            1:       return 7'b0000110;
            7:       return 7'b0000111;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(int hold);
        @(negedge clk);
        rst = 1'b1;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk("R2 held reset code", code_o, 0);
        end
        rst = 1'b0;
    endtask

    initial begin
        int c0;
        int s0;
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 reset code", code_o, 0);
        chk("R7 reset seg", seg_o, exp_seg(0));
        do_reset(3);

        // R3 R7: long run from release
        for (int i = 0; i < 30; i++) begin
            if (i > 0) @(negedge clk);
            chk("R3 sequence", code_o, exp_code(i));
            chk("R7 seg", seg_o, exp_seg(exp_code(i)));
        end

        // R1 R4 R6: reset after every step count
        for (int j = 0; j < 8; j++) begin
            do_reset(1);
            for (int i = 0; i <= j; i++) begin
                if (i > 0) @(negedge clk);
                chk("R4 sequence after reset", code_o, exp_code(i));
            end
            c0 = code_o;
            s0 = seg_o;
            rst = 1'b1;
            #1;
            chk("R6 code unaffected by rst", code_o, c0);
            chk("R6 seg unaffected by rst", seg_o, s0);
            rst = 1'b0;
            #1;
            chk("R6 code unaffected by rst low", code_o, c0);
            rst = 1'b1;
            @(negedge clk);
            chk("R1 mid-sequence reset", code_o, 0);
            chk("R7 seg after reset", seg_o, exp_seg(0));
            rst = 1'b0;
        end

        // R2: long hold
        do_reset(6);
        @(negedge clk);
        chk("R3 first after hold", code_o, 1);
        @(negedge clk);
        chk("R5 seven code", code_o, 7);
        @(negedge clk);
        chk("R5 one after seven", code_o, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule